// File: doc/BRIEF.md
# SPI Controller Interrupt Status and Mask Unit

This unit produces the single interrupt line of a FIFO-based SPI controller. It watches the fill levels of the transmit and receive FIFOs, a mode-fault level from the shift engine and two one-cycle event pulses (receive overrun and transmit underrun). From these it builds a seven-bit status word. Each bit of that word can be enabled or masked, and the enabled bits are ORed into one registered interrupt.

The FIFO level conditions are evaluated every cycle. Transmit "room available" and receive "data available" are compared against two thresholds that software can program, so the interrupt rate can be tuned to the FIFO depth. The two event conditions are latched. They stay set until software writes a 1 to their status bit.

The enable set is changed only through a set register and a clear register. A 0 in either write leaves that source alone, so several agents can change their own sources without a read-modify-write. Software reaches everything through a small word-wide register port. Writes take effect on the clock edge. Read data is registered and appears one cycle after the address.

Top module: `spi_irq_unit`

## Requirements
- R1: After a synchronous reset the enable set is all zero, both latched bits are clear, both thresholds read 1, `irq` is 0 and `reg_rdata` is 0.
- R2: A read of offset 0x04 returns the status word in bits 6:0 with zeros above. The bits are: 0 receive overrun, 1 mode fault, 2 transmit room, 3 transmit full, 4 receive data, 5 receive full, 6 transmit underrun. Read data appears on `reg_rdata` one cycle after the address is presented. Unmapped offsets, and the set and clear offsets, read 0.
- R3: Status bit 2 is 1 exactly while `tx_level` is strictly less than the transmit threshold.
- R4: Status bit 4 is 1 exactly while `rx_level` is greater than or equal to the receive threshold.
- R5: Status bit 3 is 1 while `tx_level` equals DEPTH, and bit 5 is 1 while `rx_level` equals DEPTH. Bit 1 follows `mode_fault`.
- R6: A pulse on `rx_ovf_pulse` sets bit 0 and a pulse on `tx_udf_pulse` sets bit 6. Each bit stays set after its pulse ends.
- R7: Writing offset 0x04 clears each latched bit whose data bit is 1 and leaves the others alone. A pulse in the same cycle as a clear of the same bit keeps that bit set.
- R8: A write to offset 0x08 enables the sources whose data bits are 1. A write to 0x0C disables the sources whose data bits are 1. Zero bits leave their sources unchanged. Offset 0x10 reads the enable set, with 1 meaning enabled.
- R9: `irq` is the OR over the status bits that are both 1 and enabled. It is registered, so it follows a change one cycle after the edge that made it.
- R10: Writes to offset 0x04 have no effect on status bits 1 to 5.
- R11: Offsets 0x28 and 0x2C hold the transmit and receive thresholds in the low LVL_W bits. They are written and read back independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_ovf_pulse | input | 1 | One-cycle receive overrun event |
| tx_udf_pulse | input | 1 | One-cycle transmit underrun event |
| mode_fault | input | 1 | Mode-fault level from the shift engine |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq | output | 1 | Registered interrupt request |

## Verification
Suppose a latched event bit is lost or cleared when it should not be. A status read then shows it one cycle later, and `irq` drops on the next edge if that source is enabled. A wrong enable set shows up at offset 0x10 on the next read, and it also makes `irq` differ within one cycle of the write. A threshold compare that is off by one shows only when the level sits exactly at the threshold. For that reason the bench puts each level at the threshold and one count below it, and reads the status each time.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int NSRC   = 7;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;

  // status bit positions (software decodes these)
  localparam int B_RXOVF = 0;
  localparam int B_MODF  = 1;
  localparam int B_TXNF  = 2;
  localparam int B_TXF   = 3;
  localparam int B_RXNE  = 4;
  localparam int B_RXF   = 5;
  localparam int B_TXUF  = 6;

  localparam logic [NSRC-1:0] STICKY_SET = (NSRC'(1) << B_RXOVF) | (NSRC'(1) << B_TXUF);

  localparam logic [ADDR_W-1:0] A_STAT  = 6'h04;
  localparam logic [ADDR_W-1:0] A_ENSET = 6'h08;
  localparam logic [ADDR_W-1:0] A_ENCLR = 6'h0C;
  localparam logic [ADDR_W-1:0] A_MASK  = 6'h10;
  localparam logic [ADDR_W-1:0] A_TXTHR = 6'h28;
  localparam logic [ADDR_W-1:0] A_RXTHR = 6'h2C;
endpackage

// File: rtl/spi_irq_levels.sv
module spi_irq_levels
  import spi_irq_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_thr,
  input  logic [LVL_W-1:0] rx_thr,
  input  logic             mode_fault,
  output logic [NSRC-1:0]  lvl_bits
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  always_comb begin
    lvl_bits         = '0;
    lvl_bits[B_MODF] = mode_fault;
    lvl_bits[B_TXNF] = (tx_level < tx_thr);
    lvl_bits[B_TXF]  = (tx_level == FULL);
    lvl_bits[B_RXNE] = (rx_level >= rx_thr);
    lvl_bits[B_RXF]  = (rx_level == FULL);
  end

  // R5
  rxfull_implies_data_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_level == FULL && rx_thr <= FULL) |-> lvl_bits[B_RXNE]);
endmodule

// File: rtl/spi_irq_sticky.sv
module spi_irq_sticky
  import spi_irq_pkg::*;
#(
  parameter logic [NSRC-1:0] KEEP = STICKY_SET
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] ev,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] q
);
  logic [NSRC-1:0] unused_inputs;
  assign unused_inputs = (ev | clr) & ~KEEP;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    if (KEEP[i]) begin : g_flop
      always_ff @(posedge clk) begin
        if (rst)        q[i] <= 1'b0;
        else if (ev[i]) q[i] <= 1'b1;
        else if (clr[i]) q[i] <= 1'b0;
      end

      // R6
      sticky_set_chk: assert property (@(posedge clk) disable iff (rst)
        ev[i] |=> q[i]);
      // R7
      sticky_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr[i] && !ev[i]) |=> !q[i]);
      // R6
      sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (q[i] && !clr[i]) |=> q[i]);
    end else begin : g_none
      assign q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/spi_irq_mask.sv
module spi_irq_mask
  import spi_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            set_we,
  input  logic            clr_we,
  input  logic [NSRC-1:0] wbits,
  output logic [NSRC-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (rst)         en_q <= '0;
    else if (set_we) en_q <= en_q | wbits;
    else if (clr_we) en_q <= en_q & ~wbits;
  end

  // R8
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    set_we |=> ((en_q & $past(wbits)) == $past(wbits)));
  // R8
  mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !set_we) |=> ((en_q & $past(wbits)) == '0));
  // R8
  mask_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (set_we || clr_we) |=> ((en_q & ~$past(wbits)) == ($past(en_q) & ~$past(wbits))));
  // R8
  mask_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!set_we && !clr_we) |=> $stable(en_q));
endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
  import spi_irq_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              rx_ovf_pulse,
  input  logic              tx_udf_pulse,
  input  logic              mode_fault,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [LVL_W-1:0] tx_thr, rx_thr;
  logic [NSRC-1:0]  lvl_bits, sticky_q, en_q, status, ev, clr;
  logic [DATA_W-1:0] rd_next;
  logic [DATA_W-NSRC-1:0] unused_wdata;
  assign unused_wdata = reg_wdata[DATA_W-1:NSRC];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_thr <= LVL_W'(1);
      rx_thr <= LVL_W'(1);
    end else if (reg_we) begin
      if (reg_addr == A_TXTHR) tx_thr <= reg_wdata[LVL_W-1:0];
      if (reg_addr == A_RXTHR) rx_thr <= reg_wdata[LVL_W-1:0];
    end
  end

  spi_irq_levels #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_levels (
    .clk(clk), .rst(rst), .tx_level(tx_level), .rx_level(rx_level),
    .tx_thr(tx_thr), .rx_thr(rx_thr), .mode_fault(mode_fault),
    .lvl_bits(lvl_bits)
  );

  always_comb begin
    ev          = '0;
    ev[B_RXOVF] = rx_ovf_pulse;
    ev[B_TXUF]  = tx_udf_pulse;
    clr         = (reg_we && reg_addr == A_STAT) ? reg_wdata[NSRC-1:0] : '0;
  end

  spi_irq_sticky #(.KEEP(STICKY_SET)) u_sticky (
    .clk(clk), .rst(rst), .ev(ev), .clr(clr), .q(sticky_q)
  );

  spi_irq_mask u_mask (
    .clk(clk), .rst(rst),
    .set_we(reg_we && reg_addr == A_ENSET),
    .clr_we(reg_we && reg_addr == A_ENCLR),
    .wbits(reg_wdata[NSRC-1:0]), .en_q(en_q)
  );

  assign status = lvl_bits | sticky_q;

  always_comb begin
    case (reg_addr)
      A_STAT:  rd_next = DATA_W'(status);
      A_MASK:  rd_next = DATA_W'(en_q);
      A_TXTHR: rd_next = DATA_W'(tx_thr);
      A_RXTHR: rd_next = DATA_W'(rx_thr);
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      reg_rdata <= rd_next;
      irq       <= |(status & en_q);
    end
  end

  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> !irq);
  // R9
  sticky_enabled_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (|(sticky_q & en_q)) |=> irq);
  // R2
  rdata_high_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(reg_addr == A_STAT) |-> (reg_rdata[DATA_W-1:NSRC] == '0));
endmodule

// File: tb/spi_irq_unit_test.sv
module spi_irq_unit_test;
  localparam int DEPTH = 128;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LVL_W-1:0] tx_level = '0, rx_level = '0;
  logic rx_ovf_pulse = 1'b0, tx_udf_pulse = 1'b0, mode_fault = 1'b0;
  logic reg_we = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // model state
  int txl = 0, rxl = 0, tthr = 1, rthr = 1;
  bit modf = 0;
  logic [6:0] stk = '0;

  always #2.5 clk = ~clk;

  spi_irq_unit #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .tx_level(tx_level), .rx_level(rx_level),
    .rx_ovf_pulse(rx_ovf_pulse), .tx_udf_pulse(tx_udf_pulse),
    .mode_fault(mode_fault), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [31:0] exp_stat();
    logic [31:0] s = '0;
    s[0] = stk[0];
    s[1] = modf;
    s[2] = (txl < tthr);
    s[3] = (txl == DEPTH);
    s[4] = (rxl >= rthr);
    s[5] = (rxl == DEPTH);
    s[6] = stk[6];
    return s;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk); reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_we = 1'b0; reg_addr = a;
    @(posedge clk);
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic set_lvl(input int t, input int r, input bit m);
    @(negedge clk);
    txl = t; rxl = r; modf = m;
    tx_level = LVL_W'(t); rx_level = LVL_W'(r); mode_fault = m;
  endtask

  task automatic next_irq(input string req, input bit exp);
    @(posedge clk); @(negedge clk);
    chk(req, {31'b0, irq}, {31'b0, exp});
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", {31'b0, irq}, 32'd0);
    chk("R1 rdata", reg_rdata, 32'd0);
    rd(6'h04, d); chk("R1 status", d, 32'h04);
    rd(6'h10, d); chk("R1 mask", d, 32'h0);
    rd(6'h28, d); chk("R1 txthr", d, 32'd1);
    rd(6'h2C, d); chk("R1 rxthr", d, 32'd1);
    rd(6'h20, d); chk("R2 unmapped", d, 32'h0);
    rd(6'h08, d); chk("R2 enset reads 0", d, 32'h0);
  endtask

  task automatic t_thresholds();
    logic [31:0] d;
    wr(6'h28, 32'd32); tthr = 32;
    wr(6'h2C, 32'd4);  rthr = 4;
    rd(6'h28, d); chk("R11 txthr", d, 32'd32);
    rd(6'h2C, d); chk("R11 rxthr", d, 32'd4);
    set_lvl(31, 3, 0);  rd(6'h04, d); chk("R3 below thr / R4 below", d, exp_stat());
    set_lvl(32, 4, 0);  rd(6'h04, d); chk("R3 at thr / R4 at thr", d, exp_stat());
    set_lvl(33, 5, 1);  rd(6'h04, d); chk("R4 above / R5 modf", d, exp_stat());
    set_lvl(DEPTH, DEPTH, 0); rd(6'h04, d); chk("R5 both full", d, 32'h38);
    set_lvl(0, 0, 0);   rd(6'h04, d); chk("R2 empty fifos", d, 32'h04);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    @(negedge clk); rx_ovf_pulse = 1'b1;
    @(negedge clk); rx_ovf_pulse = 1'b0; stk[0] = 1'b1;
    rd(6'h04, d); chk("R6 overrun held", d, exp_stat());
    @(negedge clk); tx_udf_pulse = 1'b1;
    @(negedge clk); tx_udf_pulse = 1'b0; stk[6] = 1'b1;
    rd(6'h04, d); chk("R6 underrun held", d, exp_stat());
    wr(6'h04, 32'h40); stk[6] = 1'b0;
    rd(6'h04, d); chk("R7 clear one only", d, exp_stat());
    // same-cycle pulse and clear
    @(negedge clk); reg_we = 1'b1; reg_addr = 6'h04; reg_wdata = 32'h01; rx_ovf_pulse = 1'b1;
    @(posedge clk);
    @(negedge clk); reg_we = 1'b0; reg_wdata = '0; rx_ovf_pulse = 1'b0;
    rd(6'h04, d); chk("R7 pulse beats clear", d, exp_stat());
    wr(6'h04, 32'h01); stk[0] = 1'b0;
    rd(6'h04, d); chk("R7 cleared", d, exp_stat());
  endtask

  task automatic t_readonly();
    logic [31:0] d;
    set_lvl(DEPTH, 0, 1);
    wr(6'h04, 32'h3E);
    rd(6'h04, d); chk("R10 write ignored (set)", d, exp_stat());
    set_lvl(0, DEPTH, 0);
    wr(6'h04, 32'h7F);
    rd(6'h04, d); chk("R10 write ignored (clr)", d, exp_stat());
    set_lvl(0, 0, 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(6'h08, 32'h14); rd(6'h10, d); chk("R8 set", d, 32'h14);
    wr(6'h08, 32'h01); rd(6'h10, d); chk("R8 set keeps others", d, 32'h15);
    wr(6'h0C, 32'h04); rd(6'h10, d); chk("R8 clear one", d, 32'h11);
    wr(6'h0C, 32'h00); rd(6'h10, d); chk("R8 zero write", d, 32'h11);
    wr(6'h0C, 32'h7F); rd(6'h10, d); chk("R8 clear all", d, 32'h00);
  endtask

  task automatic t_irq();
    // tthr=32 rthr=4; levels 0,0: bit2 active only
    set_lvl(0, 0, 0);
    next_irq("R9 all masked", 1'b0);
    wr(6'h08, 32'h04);
    chk("R9 not yet", {31'b0, irq}, 32'd0);
    next_irq("R9 one cycle later", 1'b1);
    wr(6'h0C, 32'h04);
    next_irq("R9 masked again", 1'b0);
    wr(6'h08, 32'h10);
    set_lvl(0, 3, 0);
    next_irq("R9 rx below thr", 1'b0);
    set_lvl(0, 4, 0);
    next_irq("R9 rx at thr", 1'b1);
    set_lvl(0, 0, 0);
    wr(6'h0C, 32'h10);
    wr(6'h08, 32'h40);
    @(negedge clk); tx_udf_pulse = 1'b1;
    @(negedge clk); tx_udf_pulse = 1'b0;
    next_irq("R9 sticky source", 1'b1);
    next_irq("R6 irq stays", 1'b1);
    wr(6'h04, 32'h40);
    next_irq("R7 irq after clear", 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_thresholds();
    t_sticky();
    t_readonly();
    t_mask();
    t_irq();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule